// File: doc/BRIEF.md
# Line-Aliasing Outstanding Request Tracker

This block sits between a processor-side memory port and a cache controller and keeps track of every request that has been sent downstream and not yet answered. Each request is reduced to its cache-line address and held in one of two small fully associative tables. Read-class traffic (plain loads and instruction fetches) goes to one table. Everything that needs write permission on the line goes to the other table: stores, flushes, load-linked and store-conditional operations, locked read-modify-write halves, and reads that carry a store-check hint.

A request is answered in the cycle it is presented. It is refused as buffer-full when too many requests are in flight or when its table has no free slot. It is refused as aliased when either table already holds its line. When it is accepted, it is recorded with the current cycle as its issue time and forwarded downstream with a downstream type and a lookup latency. Completions remove entries by line address. Four counters record which kind of request collided with which kind of entry. A watchdog runs while requests are in flight and raises a sticky deadlock flag if any entry has grown too old.

Top module: `line_req_tracker`

## Requirements
- R1: After reset, `outstanding`, `deadlock` and all four alias counters are zero, and no request is issued until one is accepted.
- R2: When `outstanding` is at or above `MAX_OUT`, a presented request gets status buffer-full (01). This check comes before any alias check, and no alias counter moves.
- R3: Requests are sorted by these inputs. `req_cmd` is 00 for a read, 01 for a write, and 1x for a flush. `req_llsc` takes priority over `req_locked`, and both take priority over `req_cmd`. The write table receives: `req_llsc` requests, `req_locked` requests, writes, flushes, and reads with `req_store_chk` set but `req_ifetch` clear. The read table receives: plain reads and reads with `req_ifetch` set.
- R4: The line address is `req_addr >> log2(LINE_BYTES)`. A request whose line is held by either table gets status aliased (10) and is not recorded. The counters are updated as follows:
  - A write-class request that meets a read entry increments `st_on_ld`; otherwise, if it meets a write entry, it increments `st_on_st`.
  - A read-class request that meets a write entry increments `ld_on_st`; otherwise, if it meets a read entry, it increments `ld_on_ld`.
- R5: A request that is neither over the limit nor aliased, but whose table has no free slot, gets status buffer-full (01).
- R6: An accepted request raises `iss_valid` in the same cycle, with `iss_addr` equal to `req_addr`. `iss_type` is set as follows: 0 for a load, 1 for an instruction fetch, 2 for a store-type request (store, locked request, or store-check read), 3 for an atomic request (load-linked or store-conditional), and 4 for a flush.
- R7: `iss_lat` equals `ICACHE_LAT` when `iss_type` is 1, and `DCACHE_LAT` otherwise.
- R8: `req_status` is valid in the same cycle as `req_valid`. It is 00 when the request is issued, 01 when it is refused as buffer-full, and 10 when it is refused as aliased.
- R9: `outstanding` always equals the number of held entries. It rises by one the cycle after an acceptance and falls by one the cycle after a matching completion; both in the same cycle leave it unchanged.
- R10: A completion removes the entry whose line equals `cpl_line`, from the table chosen by `cpl_wr` (1 for the write table). The line can then be accepted again.
- R11: A completion that finds no such line in the chosen table raises `cpl_miss` in the same cycle and changes no entry.
- R12: The watchdog is armed as follows:
  - When it is idle, an acceptance arms it.
  - It checks `DL_THRESH` cycles after arming. If any entry's age (current cycle minus issue cycle) is at least `DL_THRESH`, it sets `deadlock`, and the flag stays set until reset.
  - After a check, it re-arms only if requests remain outstanding; otherwise it goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_cmd | input | 2 | 00 read, 01 write, 1x flush |
| req_llsc | input | 1 | Load-linked / store-conditional attribute |
| req_locked | input | 1 | Locked read-modify-write attribute |
| req_ifetch | input | 1 | Instruction fetch attribute |
| req_store_chk | input | 1 | Read that needs write permission |
| req_status | output | 2 | Same-cycle answer to the request |
| iss_valid | output | 1 | Request forwarded downstream |
| iss_addr | output | ADDR_W | Forwarded address |
| iss_type | output | 3 | Downstream request type |
| iss_lat | output | LAT_W | Lookup latency for the forwarded request |
| cpl_valid | input | 1 | Completion presented |
| cpl_wr | input | 1 | Completion targets the write table |
| cpl_line | input | ADDR_W-log2(LINE_BYTES) | Completed line address |
| cpl_miss | output | 1 | Completion matched no entry |
| outstanding | output | OCW | Number of held entries |
| deadlock | output | 1 | Sticky watchdog flag |
| st_on_ld | output | CNT_W | Write-class request hit a read entry |
| st_on_st | output | CNT_W | Write-class request hit a write entry |
| ld_on_ld | output | CNT_W | Read-class request hit a read entry |
| ld_on_st | output | CNT_W | Read-class request hit a write entry |

## Verification
The hardest case to reach is the exact age boundary of the watchdog. The watchdog checks only at points fixed by the first acceptance after it went idle, so its phase depends on all earlier traffic. The stimulus first drains every entry and idles long enough for a check to find the tables empty and disarm the watchdog. It then accepts a single load and completes it one cycle before the threshold, and no flag is expected. Finally it accepts another load, leaves it held, and samples the flag in the check cycle and in the cycle after it.

// File: rtl/line_req_tracker.sv
module line_req_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int DL_THRESH  = 256,
  parameter int ICACHE_LAT = 1,
  parameter int DCACHE_LAT = 3,
  parameter int LAT_W      = 4,
  parameter int CNT_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [1:0]                            req_cmd,
  input  logic                                  req_llsc,
  input  logic                                  req_locked,
  input  logic                                  req_ifetch,
  input  logic                                  req_store_chk,
  output logic [1:0]                            req_status,
  output logic                                  iss_valid,
  output logic [ADDR_W-1:0]                     iss_addr,
  output logic [2:0]                            iss_type,
  output logic [LAT_W-1:0]                      iss_lat,
  input  logic                                  cpl_valid,
  input  logic                                  cpl_wr,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  cpl_line,
  output logic                                  cpl_miss,
  output logic [$clog2(RD_DEPTH+WR_DEPTH+1)-1:0] outstanding,
  output logic                                  deadlock,
  output logic [CNT_W-1:0]                      st_on_ld,
  output logic [CNT_W-1:0]                      st_on_st,
  output logic [CNT_W-1:0]                      ld_on_ld,
  output logic [CNT_W-1:0]                      ld_on_st
);
  localparam int OFF   = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF;
  localparam int OCW   = $clog2(RD_DEPTH + WR_DEPTH + 1);
  localparam int TS_W  = $clog2(DL_THRESH) + 2;
  localparam int WDW   = $clog2(DL_THRESH + 1);
  localparam int RIW   = (RD_DEPTH > 1) ? $clog2(RD_DEPTH) : 1;
  localparam int WIW   = (WR_DEPTH > 1) ? $clog2(WR_DEPTH) : 1;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_FULL  = 2'd1;
  localparam logic [1:0] ST_ALIAS = 2'd2;

  localparam logic [2:0] T_LOAD   = 3'd0;
  localparam logic [2:0] T_IFETCH = 3'd1;
  localparam logic [2:0] T_STORE  = 3'd2;
  localparam logic [2:0] T_ATOMIC = 3'd3;
  localparam logic [2:0] T_FLUSH  = 3'd4;

  localparam logic [OCW-1:0]  MAX_C = OCW'(MAX_OUT);
  localparam logic [TS_W-1:0] THR_T = TS_W'(DL_THRESH);
  localparam logic [WDW-1:0]  THR_W = WDW'(DL_THRESH);

  logic [RD_DEPTH-1:0] rd_v;
  logic [TAG_W-1:0]    rd_tag [RD_DEPTH];
  logic [TS_W-1:0]     rd_ts  [RD_DEPTH];
  logic [WR_DEPTH-1:0] wr_v;
  logic [TAG_W-1:0]    wr_tag [WR_DEPTH];
  logic [TS_W-1:0]     wr_ts  [WR_DEPTH];

  logic [TS_W-1:0] cyc;
  logic            wd_armed;
  logic [WDW-1:0]  wd_cnt;

  logic [TAG_W-1:0]    req_tag;
  logic [RD_DEPTH-1:0] rd_hit, rd_cm, rd_set, rd_clr;
  logic [WR_DEPTH-1:0] wr_hit, wr_cm, wr_set, wr_clr;
  logic [RIW-1:0]      rd_free;
  logic [WIW-1:0]      wr_free;
  logic                is_wcls, cap_full, aliased, slot_ok, accept, cpl_hit, any_old;
  logic [OCW-1:0]      nxt_out;

  assign req_tag = req_addr[ADDR_W-1:OFF];

  always_comb begin
    is_wcls  = 1'b1;
    iss_type = T_STORE;
    if (req_llsc)              iss_type = T_ATOMIC;
    else if (req_locked)       iss_type = T_STORE;
    else if (req_cmd[1])       iss_type = T_FLUSH;
    else if (req_cmd[0])       iss_type = T_STORE;
    else if (req_ifetch) begin iss_type = T_IFETCH; is_wcls = 1'b0; end
    else if (req_store_chk)    iss_type = T_STORE;
    else begin                 iss_type = T_LOAD;   is_wcls = 1'b0; end
  end

  always_comb begin
    rd_free = '0;
    any_old = 1'b0;
    for (int i = RD_DEPTH - 1; i >= 0; i--) begin
      rd_hit[i] = rd_v[i] && (rd_tag[i] == req_tag);
      rd_cm[i]  = rd_v[i] && (rd_tag[i] == cpl_line);
      if (!rd_v[i]) rd_free = RIW'(i);
      if (rd_v[i] && (TS_W'(cyc - rd_ts[i]) >= THR_T)) any_old = 1'b1;
    end
    wr_free = '0;
    for (int i = WR_DEPTH - 1; i >= 0; i--) begin
      wr_hit[i] = wr_v[i] && (wr_tag[i] == req_tag);
      wr_cm[i]  = wr_v[i] && (wr_tag[i] == cpl_line);
      if (!wr_v[i]) wr_free = WIW'(i);
      if (wr_v[i] && (TS_W'(cyc - wr_ts[i]) >= THR_T)) any_old = 1'b1;
    end
  end

  assign cap_full = outstanding >= MAX_C;
  assign aliased  = (|rd_hit) || (|wr_hit);
  assign slot_ok  = is_wcls ? !(&wr_v) : !(&rd_v);

  assign req_status = !req_valid ? ST_OK    :
                      cap_full   ? ST_FULL  :
                      aliased    ? ST_ALIAS :
                      !slot_ok   ? ST_FULL  : ST_OK;

  assign accept    = req_valid && (req_status == ST_OK);
  assign iss_valid = accept;
  assign iss_addr  = req_addr;
  assign iss_lat   = (iss_type == T_IFETCH) ? LAT_W'(ICACHE_LAT) : LAT_W'(DCACHE_LAT);

  assign cpl_hit  = cpl_valid && (cpl_wr ? (|wr_cm) : (|rd_cm));
  assign cpl_miss = cpl_valid && !cpl_hit;

  assign rd_set = (accept && !is_wcls) ? (RD_DEPTH'(1) << rd_free) : '0;
  assign wr_set = (accept &&  is_wcls) ? (WR_DEPTH'(1) << wr_free) : '0;
  assign rd_clr = (cpl_valid && !cpl_wr) ? rd_cm : '0;
  assign wr_clr = (cpl_valid &&  cpl_wr) ? wr_cm : '0;
  assign nxt_out = outstanding + OCW'(accept) - OCW'(cpl_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v <= '0;
      wr_v <= '0;
      for (int i = 0; i < RD_DEPTH; i++) begin
        rd_tag[i] <= '0;
        rd_ts[i]  <= '0;
      end
      for (int i = 0; i < WR_DEPTH; i++) begin
        wr_tag[i] <= '0;
        wr_ts[i]  <= '0;
      end
    end else begin
      rd_v <= (rd_v & ~rd_clr) | rd_set;
      wr_v <= (wr_v & ~wr_clr) | wr_set;
      if (accept && !is_wcls) begin
        rd_tag[rd_free] <= req_tag;
        rd_ts[rd_free]  <= cyc;
      end
      if (accept && is_wcls) begin
        wr_tag[wr_free] <= req_tag;
        wr_ts[wr_free]  <= cyc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= '0;
      cyc         <= '0;
      st_on_ld    <= '0;
      st_on_st    <= '0;
      ld_on_ld    <= '0;
      ld_on_st    <= '0;
    end else begin
      outstanding <= nxt_out;
      cyc         <= cyc + TS_W'(1);
      if (req_valid && !cap_full && aliased) begin
        if (is_wcls) begin
          if (|rd_hit) st_on_ld <= st_on_ld + CNT_W'(1);
          else         st_on_st <= st_on_st + CNT_W'(1);
        end else begin
          if (|wr_hit) ld_on_st <= ld_on_st + CNT_W'(1);
          else         ld_on_ld <= ld_on_ld + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_armed <= 1'b0;
      wd_cnt   <= '0;
      deadlock <= 1'b0;
    end else if (!wd_armed) begin
      if (accept) begin
        wd_armed <= 1'b1;
        wd_cnt   <= THR_W;
      end
    end else if (wd_cnt == WDW'(1)) begin
      if (any_old) deadlock <= 1'b1;
      if (nxt_out != '0) wd_cnt   <= THR_W;
      else               wd_armed <= 1'b0;
    end else begin
      wd_cnt <= wd_cnt - WDW'(1);
    end
  end
endmodule

// File: rtl/line_req_tracker_chk.sv
module line_req_tracker_chk #(
  parameter int RD_DEPTH = 4,
  parameter int WR_DEPTH = 4,
  parameter int TAG_W    = 26,
  parameter int OCW      = 4,
  parameter int MAX_OUT  = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_status,
  input logic                iss_valid,
  input logic [2:0]          iss_type,
  input logic                cpl_valid,
  input logic                cpl_miss,
  input logic [OCW-1:0]      outstanding,
  input logic                deadlock,
  input logic [RD_DEPTH-1:0] rd_v,
  input logic [WR_DEPTH-1:0] wr_v,
  input logic [TAG_W-1:0]    rd_tag [RD_DEPTH],
  input logic [TAG_W-1:0]    wr_tag [WR_DEPTH]
);
  logic dup;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < RD_DEPTH; i++) begin
      for (int j = 0; j < WR_DEPTH; j++)
        if (rd_v[i] && wr_v[j] && rd_tag[i] == wr_tag[j]) dup = 1'b1;
      for (int k = i + 1; k < RD_DEPTH; k++)
        if (rd_v[i] && rd_v[k] && rd_tag[i] == rd_tag[k]) dup = 1'b1;
    end
    for (int i = 0; i < WR_DEPTH; i++)
      for (int k = i + 1; k < WR_DEPTH; k++)
        if (wr_v[i] && wr_v[k] && wr_tag[i] == wr_tag[k]) dup = 1'b1;
  end

  // R9
  occ_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding) == $countones(rd_v) + $countones(wr_v));

  // R2
  cap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && int'(outstanding) >= MAX_OUT |-> req_status == 2'd1);

  // R8
  issue_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> req_valid && req_status == 2'd0);

  // R9
  grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !(cpl_valid && !cpl_miss) |=> int'(outstanding) == int'($past(outstanding)) + 1);

  // R11
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_miss && !iss_valid |=> outstanding == $past(outstanding));

  // R12
  dl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);

  // R4
  uniq_line_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  // R6
  type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_type <= 3'd4);
endmodule

bind line_req_tracker line_req_tracker_chk #(
  .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .TAG_W(TAG_W), .OCW(OCW), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_status(req_status),
  .iss_valid(iss_valid), .iss_type(iss_type), .cpl_valid(cpl_valid), .cpl_miss(cpl_miss),
  .outstanding(outstanding), .deadlock(deadlock), .rd_v(rd_v), .wr_v(wr_v),
  .rd_tag(rd_tag), .wr_tag(wr_tag)
);

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
  localparam int THR = 64;
  localparam int MAXO = 6;
  localparam int RDD = 4;
  localparam int WRD = 4;
  localparam int ILAT = 1;
  localparam int DLAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_cmd = '0;
  logic        req_llsc = 1'b0, req_locked = 1'b0, req_ifetch = 1'b0, req_store_chk = 1'b0;
  logic [1:0]  req_status;
  logic        iss_valid;
  logic [31:0] iss_addr;
  logic [2:0]  iss_type;
  logic [3:0]  iss_lat;
  logic        cpl_valid = 1'b0, cpl_wr = 1'b0;
  logic [25:0] cpl_line = '0;
  logic        cpl_miss;
  logic [3:0]  outstanding;
  logic        deadlock;
  logic [15:0] st_on_ld, st_on_st, ld_on_ld, ld_on_st;

  line_req_tracker #(
    .RD_DEPTH(RDD), .WR_DEPTH(WRD), .MAX_OUT(MAXO), .DL_THRESH(THR),
    .ICACHE_LAT(ILAT), .DCACHE_LAT(DLAT)
  ) u_line_req_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_llsc(req_llsc), .req_locked(req_locked),
    .req_ifetch(req_ifetch), .req_store_chk(req_store_chk), .req_status(req_status),
    .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_type(iss_type), .iss_lat(iss_lat),
    .cpl_valid(cpl_valid), .cpl_wr(cpl_wr), .cpl_line(cpl_line), .cpl_miss(cpl_miss),
    .outstanding(outstanding), .deadlock(deadlock), .st_on_ld(st_on_ld),
    .st_on_st(st_on_st), .ld_on_ld(ld_on_ld), .ld_on_st(ld_on_st)
  );

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  int m_rd[$], m_rdts[$], m_wr[$], m_wrts[$];
  int mcyc = 0, m_wdc = 0, m_sl = 0, m_ss = 0, m_ll = 0, m_ls = 0;
  bit m_arm = 0, m_dl = 0;
  int seen_st, seen_type, seen_lat;
  bit seen_miss;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    int line, ety, est, q[$], cidx;
    bit wcls, acc, rhit, whit, chit;
    #2;
    line = int'(req_addr >> 6);
    wcls = 1;
    if (req_llsc) ety = 3;
    else if (req_locked) ety = 2;
    else if (req_cmd[1]) ety = 4;
    else if (req_cmd[0]) ety = 2;
    else if (req_ifetch) begin ety = 1; wcls = 0; end
    else if (req_store_chk) ety = 2;
    else begin ety = 0; wcls = 0; end
    q = m_rd.find_first_index(x) with (x == line); rhit = q.size() > 0;
    q = m_wr.find_first_index(x) with (x == line); whit = q.size() > 0;
    if (m_rd.size() + m_wr.size() >= MAXO) est = 1;
    else if (rhit || whit) est = 2;
    else if (wcls ? (m_wr.size() >= WRD) : (m_rd.size() >= RDD)) est = 1;
    else est = 0;
    acc = req_valid && est == 0;
    cidx = -1;
    if (cpl_valid) begin
      if (cpl_wr) q = m_wr.find_first_index(x) with (x == int'(cpl_line));
      else        q = m_rd.find_first_index(x) with (x == int'(cpl_line));
      if (q.size() > 0) cidx = q[0];
    end
    chit = cidx >= 0;
    seen_st = int'(req_status); seen_type = int'(iss_type);
    seen_lat = int'(iss_lat); seen_miss = cpl_miss;
    if (req_valid) chk(int'(req_status) == est, "R8 status", req_status, est);
    chk(iss_valid == acc, "R6 iss_valid", iss_valid, acc);
    if (acc) begin
      chk(int'(iss_type) == ety, "R6 iss_type", iss_type, ety);
      chk(iss_addr == req_addr, "R6 iss_addr", iss_addr, req_addr);
      chk(int'(iss_lat) == (ety == 1 ? ILAT : DLAT), "R7 iss_lat", iss_lat, ety == 1 ? ILAT : DLAT);
    end
    chk(cpl_miss == (cpl_valid && !chit), "R11 cpl_miss", cpl_miss, cpl_valid && !chit);
    chk(int'(outstanding) == m_rd.size() + m_wr.size(), "R9 outstanding", outstanding, m_rd.size() + m_wr.size());
    chk(deadlock == m_dl, "R12 deadlock", deadlock, m_dl);
    chk(int'(st_on_ld) == m_sl, "R4 st_on_ld", st_on_ld, m_sl);
    chk(int'(st_on_st) == m_ss, "R4 st_on_st", st_on_st, m_ss);
    chk(int'(ld_on_ld) == m_ll, "R4 ld_on_ld", ld_on_ld, m_ll);
    chk(int'(ld_on_st) == m_ls, "R4 ld_on_st", ld_on_st, m_ls);
    @(posedge clk);
    begin
      bit old = 0;
      int nxt;
      foreach (m_rdts[i]) if (mcyc - m_rdts[i] >= THR) old = 1;
      foreach (m_wrts[i]) if (mcyc - m_wrts[i] >= THR) old = 1;
      if (req_valid && est == 2) begin
        if (wcls) begin if (rhit) m_sl++; else m_ss++; end
        else begin if (whit) m_ls++; else m_ll++; end
      end
      if (chit) begin
        if (cpl_wr) begin m_wr.delete(cidx); m_wrts.delete(cidx); end
        else begin m_rd.delete(cidx); m_rdts.delete(cidx); end
      end
      if (acc) begin
        if (wcls) begin m_wr.push_back(line); m_wrts.push_back(mcyc); end
        else begin m_rd.push_back(line); m_rdts.push_back(mcyc); end
      end
      nxt = m_rd.size() + m_wr.size();
      if (!m_arm) begin
        if (acc) begin m_arm = 1; m_wdc = THR; end
      end else if (m_wdc == 1) begin
        if (old) m_dl = 1;
        if (nxt > 0) m_wdc = THR; else m_arm = 0;
      end else m_wdc--;
      mcyc++;
    end
    @(negedge clk);
  endtask

  task automatic clear_in();
    req_valid = 0; req_cmd = 0; req_llsc = 0; req_locked = 0;
    req_ifetch = 0; req_store_chk = 0; cpl_valid = 0; cpl_wr = 0;
  endtask

  task automatic req(int cmd, int addr, bit llsc, bit lk, bit ifx, bit sc, int exp_st, string tag);
    req_valid = 1; req_cmd = 2'(cmd); req_addr = 32'(addr);
    req_llsc = llsc; req_locked = lk; req_ifetch = ifx; req_store_chk = sc;
    cycle();
    chk(seen_st == exp_st, tag, seen_st, exp_st);
    clear_in();
  endtask

  task automatic cpl(bit wr, int addr, bit exp_miss, string tag);
    cpl_valid = 1; cpl_wr = wr; cpl_line = 26'(addr >> 6);
    cycle();
    chk(seen_miss == exp_miss, tag, seen_miss, exp_miss);
    clear_in();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outstanding == 0 && deadlock == 0, "R1 reset state", outstanding, 0);
    chk(st_on_ld == 0 && st_on_st == 0 && ld_on_ld == 0 && ld_on_st == 0, "R1 counters", st_on_ld, 0);
    chk(iss_valid == 0, "R1 no issue", iss_valid, 0);
    rst_n = 1;

    req(0, 'h1000, 0, 0, 0, 0, 0, "R6 load accepted");
    req(0, 'h2000, 0, 0, 1, 0, 0, "R7 ifetch accepted");
    req(0, 'h1008, 0, 0, 0, 0, 2, "R4 load on load");
    chk(ld_on_ld == 1, "R4 ld_on_ld count", ld_on_ld, 1);
    req(1, 'h1004, 0, 0, 0, 0, 2, "R4 store on load");
    chk(st_on_ld == 1, "R4 st_on_ld count", st_on_ld, 1);
    req(1, 'h3000, 0, 0, 0, 0, 0, "R3 store accepted");
    req(0, 'h3010, 0, 0, 0, 0, 2, "R3 load on store");
    chk(ld_on_st == 1, "R4 ld_on_st count", ld_on_st, 1);
    req(2, 'h3000, 0, 0, 0, 0, 2, "R3 flush on store");
    chk(st_on_st == 1, "R4 st_on_st count", st_on_st, 1);
    req(0, 'h4000, 1, 0, 0, 0, 0, "R6 load-linked atomic");
    req(1, 'h4000, 1, 0, 0, 0, 2, "R3 sc on ll");
    chk(st_on_st == 2, "R3 ll in write table", st_on_st, 2);
    req(0, 'h5000, 0, 1, 0, 0, 0, "R6 locked read");
    req(0, 'h6000, 0, 0, 0, 1, 0, "R3 store-check read");
    chk(outstanding == 6, "R9 six held", outstanding, 6);
    req(0, 'h6000, 0, 0, 0, 0, 1, "R2 full before alias");
    chk(ld_on_st == 1, "R2 counter unchanged", ld_on_st, 1);
    req(0, 'h7000, 0, 0, 0, 0, 1, "R2 full new line");
    cpl(0, 'h1000, 0, "R10 read completion");
    cpl(0, 'h1000, 1, "R11 repeat completion");
    chk(outstanding == 5, "R11 count unchanged", outstanding, 5);
    cpl(0, 'h3000, 1, "R10 wrong table");
    req(0, 'h3000, 0, 0, 0, 0, 2, "R10 entry kept");
    cpl(1, 'h3000, 0, "R10 write completion");
    cpl_valid = 1; cpl_wr = 1; cpl_line = 26'('h4000 >> 6);
    req(0, 'h1000, 0, 0, 0, 0, 0, "R10 line reusable");
    chk(outstanding == 4, "R9 accept with completion", outstanding, 4);
    cpl(1, 'h5000, 0, "R10 complete locked");
    cpl(1, 'h6000, 0, "R10 complete store-check");
    req(0, 'h8000, 0, 0, 0, 0, 0, "R5 third read");
    req(0, 'h9000, 0, 0, 0, 0, 0, "R5 fourth read");
    req(0, 'hA000, 0, 0, 0, 0, 1, "R5 read table full");
    req(1, 'hA000, 0, 0, 0, 0, 0, "R5 write table free");
    cpl(0, 'h2000, 0, "R10 drain");
    cpl(0, 'h1000, 0, "R10 drain");
    cpl(0, 'h8000, 0, "R10 drain");
    cpl(0, 'h9000, 0, "R10 drain");
    cpl(1, 'hA000, 0, "R10 drain");
    chk(outstanding == 0, "R9 drained", outstanding, 0);

    idle(140);
    chk(deadlock == 0, "R12 no deadlock yet", deadlock, 0);
    req(0, 'hB000, 0, 0, 0, 0, 0, "R12 arm");
    idle(THR - 2);
    cpl(0, 'hB000, 0, "R12 complete before threshold");
    idle(3);
    chk(deadlock == 0, "R12 boundary no flag", deadlock, 0);
    idle(THR);
    req(0, 'hC000, 0, 0, 0, 0, 0, "R12 rearm");
    idle(THR - 1);
    chk(deadlock == 0, "R12 check cycle", deadlock, 0);
    idle(1);
    chk(deadlock == 1, "R12 flag raised", deadlock, 1);
    cpl(0, 'hC000, 0, "R12 late completion");
    idle(4);
    chk(deadlock == 1, "R12 sticky", deadlock, 1);
    summary();
  end
endmodule